// File: doc/BRIEF.md
# Display Column Timing Generator

This block builds the column timing for a self-scanning dot-matrix plasma display. It does not use a free-running oscillator. It counts the one-cycle strobe that the CPU issues once per machine state, about every 2.5 µs. Each display column lasts a fixed number of these strobes. Inside each column the block produces three things:

- a display column clock that is low for an opening stretch of the column;
- a data-drive enable that stays off for a shorter opening stretch, so the display's data lines float high;
- a one-cycle pulse that tells the address sequencer to step to the next column.

The drive enable is also held off for as long as the display's reset pulse is active.

The core is a three-state phase machine that follows a 6-bit tick counter. `PH_BLANK` covers ticks 0 to 5: the clock is low and drive is off. `PH_SETTLE` covers ticks 6 to 9: the clock is low and drive is allowed. `PH_HIGH` covers ticks 10 to 55: the clock is high and drive is allowed. The transitions are:

- `BLANK_DONE`: `PH_BLANK` to `PH_SETTLE`, when the counter reaches 6.
- `LOW_DONE`: `PH_SETTLE` to `PH_HIGH`, when the counter reaches 10.
- `COLUMN_WRAP`: `PH_HIGH` to `PH_BLANK`, when the counter rolls from 55 back to 0.

With no strobe, the machine holds its state. All outputs come from flops in the single system clock domain. Each output therefore shows the phase of the tick count present after the clock edge on which the strobe was sampled.

Top module: `col_timing_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `col_clk`, `drive_en` and `col_start` are all 0 and the tick count is 0.
- R2: On an edge where `sync_tick` is 0, the tick count does not change, so `col_clk` keeps its value.
- R3: Each `sync_tick` advances the tick count by one. From tick 55 it returns to 0, so one column is 56 ticks.
- R4: `col_clk` is 0 while the tick count is 0 to 9 and 1 while it is 10 to 55. It takes the value for the new count in the cycle after the edge that samples the strobe.
- R5: `drive_en` is 0 while the tick count is 0 to 5, whatever the value of `reset_active`.
- R6: `drive_en` is 1 while the tick count is 6 to 55, provided `reset_active` was 0 at the same edge.
- R7: `reset_active` high at a clock edge forces `drive_en` to 0 in the following cycle, even with no strobe.
- R8: `col_start` is high for exactly one cycle: the cycle after the edge at which a strobe moves the count from 55 to 0. At all other times it is 0, and a reset edge suppresses it.
- R9: A reset in the middle of a column returns the count to 0. The next strobe then gives tick 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_tick | input | 1 | One-cycle strobe, one per CPU state |
| reset_active | input | 1 | High while the display reset pulse is asserted |
| col_clk | output | 1 | Display column clock |
| col_start | output | 1 | One-cycle pulse at the start of each column |
| drive_en | output | 1 | Enable for the display data drivers |

## Verification
The hardest case to reach from the ports is the exact moment of the wrap, the edge that turns 55 into 0. Reaching it takes 56 strobes. At that edge `col_start` rises and `col_clk` falls in the same cycle. The stimulus sends strobes with varying gaps, including back-to-back strobes across the wrap. It also toggles `reset_active` both on strobe edges and on idle edges. Finally, it applies a reset in the middle of a column and checks that counting restarts from tick 0.

// File: rtl/col_timing_pkg.sv
package col_timing_pkg;

    typedef enum logic [1:0] {
        PH_BLANK  = 2'd0,
        PH_SETTLE = 2'd1,
        PH_HIGH   = 2'd2
    } phase_e;

endpackage

// File: rtl/col_tick_counter.sv
module col_tick_counter #(
    parameter int PERIOD_TICKS = 56,
    localparam int CNT_W = $clog2(PERIOD_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [CNT_W-1:0] tick_nxt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] tick_q;

    // wrap marks the strobe that closes a column
    assign wrap = advance && (tick_q == LAST);

    always_comb begin
        if (rst) begin
            tick_nxt = '0;
        end else if (wrap) begin
            tick_nxt = '0;
        end else if (advance) begin
            tick_nxt = tick_q + CNT_W'(1);
        end else begin
            tick_nxt = tick_q;
        end
    end

    always_ff @(posedge clk) begin
        tick_q <= tick_nxt;
    end

endmodule

// File: rtl/col_phase_fsm.sv
module col_phase_fsm
    import col_timing_pkg::*;
#(
    parameter int PERIOD_TICKS = 56,
    parameter int LOW_TICKS    = 10,
    parameter int BLANK_TICKS  = 6,
    localparam int CNT_W = $clog2(PERIOD_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tick_nxt,
    input  logic             wrap,
    output phase_e           state_nxt
);

    localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_TICKS);
    localparam logic [CNT_W-1:0] LOW_END   = CNT_W'(LOW_TICKS);

    phase_e state_q;

    // Transitions: BLANK_DONE, LOW_DONE, COLUMN_WRAP
    always_comb begin
        state_nxt = state_q;
        if (rst) begin
            state_nxt = PH_BLANK;
        end else begin
            unique case (state_q)
                PH_BLANK: begin
                    if (tick_nxt == BLANK_END) state_nxt = PH_SETTLE;
                end
                PH_SETTLE: begin
                    if (tick_nxt == LOW_END) state_nxt = PH_HIGH;
                end
                PH_HIGH: begin
                    if (wrap) state_nxt = PH_BLANK;
                end
                default: state_nxt = PH_BLANK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_nxt;
    end

endmodule

// File: rtl/col_out_reg.sv
module col_out_reg
    import col_timing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e state_nxt,
    input  logic   wrap,
    input  logic   reset_active,
    output logic   col_clk,
    output logic   col_start,
    output logic   drive_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_clk   <= 1'b0;
            col_start <= 1'b0;
            drive_en  <= 1'b0;
        end else begin
            col_clk   <= (state_nxt == PH_HIGH);
            col_start <= wrap;
            drive_en  <= (state_nxt != PH_BLANK) && !reset_active;
        end
    end

endmodule

// File: rtl/col_timing_gen.sv
module col_timing_gen
    import col_timing_pkg::*;
#(
    parameter int PERIOD_TICKS = 56,
    parameter int LOW_TICKS    = 10,
    parameter int BLANK_TICKS  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_tick,
    input  logic reset_active,
    output logic col_clk,
    output logic col_start,
    output logic drive_en
);

    localparam int CNT_W = $clog2(PERIOD_TICKS);

    logic [CNT_W-1:0] tick_nxt;
    logic             wrap;
    phase_e           state_nxt;

    col_tick_counter #(
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .advance (sync_tick),
        .tick_nxt(tick_nxt),
        .wrap    (wrap)
    );

    col_phase_fsm #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .LOW_TICKS   (LOW_TICKS),
        .BLANK_TICKS (BLANK_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick_nxt (tick_nxt),
        .wrap     (wrap),
        .state_nxt(state_nxt)
    );

    col_out_reg u_out (
        .clk         (clk),
        .rst         (rst),
        .state_nxt   (state_nxt),
        .wrap        (wrap && !rst),
        .reset_active(reset_active),
        .col_clk     (col_clk),
        .col_start   (col_start),
        .drive_en    (drive_en)
    );

endmodule

// File: rtl/col_timing_chk.sv
module col_timing_chk (
    input logic clk,
    input logic rst,
    input logic sync_tick,
    input logic reset_active,
    input logic col_clk,
    input logic col_start,
    input logic drive_en
);

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!col_clk && !drive_en && !col_start));

    // R2
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(sync_tick) && !$past(rst)) |-> ($stable(col_clk) && !col_start));

    // R8
    a_r8_start_needs_tick: assert property (@(posedge clk) disable iff (rst)
        col_start |-> $past(sync_tick));

    // R8
    a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
        col_start |=> !col_start);

    // R4, R5
    a_r4_start_in_low: assert property (@(posedge clk) disable iff (rst)
        col_start |-> (!col_clk && !drive_en));

    // R7
    a_r7_blank_in_reset: assert property (@(posedge clk) disable iff (rst)
        $past(reset_active) |-> !drive_en);

    // R4
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(col_clk) |-> $past(sync_tick));

endmodule

bind col_timing_gen col_timing_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_tick   (sync_tick),
    .reset_active(reset_active),
    .col_clk     (col_clk),
    .col_start   (col_start),
    .drive_en    (drive_en)
);

// File: tb/test_col_timing_gen.sv
module test_col_timing_gen;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_tick = 1'b0;
    logic reset_active = 1'b0;
    logic col_clk, col_start, drive_en;

    typedef struct {
        logic  clk_e;
        logic  start_e;
        logic  drv_e;
        string tag_clk;
        string tag_start;
        string tag_drv;
    } item_t;

    item_t exp_q[$];
    int vectors = 0;
    int miscompares = 0;
    int m_tick = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    col_timing_gen i_col_timing_gen (
        .clk         (clk),
        .rst         (rst),
        .sync_tick   (sync_tick),
        .reset_active(reset_active),
        .col_clk     (col_clk),
        .col_start   (col_start),
        .drive_en    (drive_en)
    );

    // driver: sets inputs at negedge and pushes the expected result
    task automatic cyc(input logic r, input logic t, input logic ra);
        item_t it;
        bit wr;
        @(negedge clk);
        rst = r;
        sync_tick = t;
        reset_active = ra;
        if (r) begin
            m_tick = 0;
            it.clk_e = 0; it.start_e = 0; it.drv_e = 0;
            it.tag_clk = "R1 R9"; it.tag_start = "R1 R8"; it.tag_drv = "R1";
        end else begin
            wr = t && (m_tick == 55);
            if (wr) m_tick = 0;
            else if (t) m_tick = m_tick + 1;
            it.clk_e   = (m_tick >= 10);
            it.start_e = wr;
            it.drv_e   = (m_tick >= 6) && !ra;
            it.tag_clk   = t ? "R3 R4" : "R2";
            it.tag_start = "R8";
            it.tag_drv   = ra ? "R7" : ((m_tick < 6) ? "R5" : "R6");
        end
        exp_q.push_back(it);
    endtask

    task automatic cmp(input logic act, input logic e, input string tag, input string nm);
        vectors++;
        if (act !== e) begin
            miscompares++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, e, $time);
        end
    endtask

    // monitor
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                cmp(col_clk,   it.clk_e,   it.tag_clk,   "col_clk");
                cmp(col_start, it.start_e, it.tag_start, "col_start");
                cmp(drive_en,  it.drv_e,   it.tag_drv,   "drive_en");
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        // R2: idle without strobes, reset_active toggling
        for (int i = 0; i < 4; i++) cyc(0, 0, i[0]);
        // R3 R4 R5 R6 R8: two columns with back-to-back strobes
        for (int i = 0; i < 112; i++) cyc(0, 1, 0);
        // uneven gaps for three columns
        for (int i = 0; i < 168; i++) begin
            cyc(0, 1, 0);
            for (int g = 0; g < (i % 3); g++) cyc(0, 0, 0);
        end
        // R7: reset_active across a column, on strobe and idle edges
        for (int i = 0; i < 56; i++) begin
            cyc(0, 1, (i >= 3 && i < 20) || (i >= 40 && i < 45));
            cyc(0, 0, (i % 7) == 0);
        end
        // R9: reset in the middle of a column
        for (int i = 0; i < 30; i++) cyc(0, 1, 0);
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        for (int i = 0; i < 60; i++) cyc(0, 1, 0);
        // reset on the wrap strobe: R8 suppressed
        for (int i = 0; i < 51; i++) cyc(0, 1, 0);
        cyc(1, 1, 0);
        for (int i = 0; i < 60; i++) cyc(0, 1, i[2]);
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule